// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns bytes written by a processor into asynchronous serial frames on one output line. A byte written through a simple write strobe lands in a holding buffer. As soon as the output shifter is idle, the byte moves into the shifter, and the buffer is free again. The processor can therefore queue the next byte while the current frame is still on the line.

Every frame starts with one low start bit. Eight data bits follow, least significant bit first, then one high stop bit. Between frames the line rests high. Bit timing comes from a transmit-clock enable input. Each bit lasts a fixed number of enable pulses, and that number (1, 16 or 64) is picked by a select input. Two flags are reported. One shows that the holding buffer can take a byte. The other shows that no byte is held and no frame is in progress.

Top module: `dbl_serial_tx`

## Requirements
- R1: After a synchronous reset, tx_out is high, buf_ready is high and all_sent is high.
- R2: Each frame drives tx_out low for the start bit, then wr_data bit 0 through bit 7 in that order, then high for the stop bit; between frames tx_out is high.
- R3: When the shifter is idle and the holding buffer is full, the byte moves into the shifter on the next clock edge. From that edge tx_out is low (start bit) and buf_ready is high again while the frame shifts.
- R4: A write (wr_en high) while buf_ready is low is ignored. The held byte is not replaced, and no extra frame is sent.
- R5: Each bit lasts exactly F pulses of tick_en, where F is 1 for div_sel 2'b00, 16 for 2'b01 and 64 for 2'b10 or 2'b11. tx_out does not change while tick_en stays low, except when a new frame starts.
- R6: all_sent falls on the edge that accepts a write. It stays low until the stop bit has lasted its full F pulses and the holding buffer is also empty. It then rises on the next edge.
- R7: A reset during a frame returns tx_out high at once, and drops both the frame in progress and any held byte.
- R8: buf_ready is low from the edge that accepts a write until the edge that moves the byte into the shifter, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Transmit-clock enable pulse, one system clock wide |
| div_sel | input | 2 | Enable pulses per bit: 00 = 1, 01 = 16, 10/11 = 64 |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to send |
| tx_out | output | 1 | Serial line, idle high |
| buf_ready | output | 1 | Holding buffer empty and able to accept a byte |
| all_sent | output | 1 | No byte held and no frame in progress |

## Verification
A wrong bit index or shift state in the shifter shows at the line itself. It appears as a data bit in the wrong place or a missing stop bit, within the frame it corrupts. A divider that counts the wrong number of pulses makes some bit longer or shorter than F enable pulses, which is seen at the first bit boundary. A stuck buffer-full state shows up as buf_ready staying low, or as a dropped or repeated frame, one frame time after the write. A wrong empty flag shows in the cycle right after the stop bit ends.

// File: rtl/tx_pkg.sv
package tx_pkg;
  typedef enum logic [1:0] {
    RATE_X1  = 2'b00,
    RATE_X16 = 2'b01,
    RATE_X64 = 2'b10,
    RATE_X64B = 2'b11
  } rate_sel_e;

  localparam int FRAME_OVERHEAD = 2;
endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] data_q,
  output logic              full_q,
  output logic              ready_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full_q  <= 1'b0;
      ready_q <= 1'b1;
      data_q  <= '0;
    end else if (take) begin
      full_q  <= 1'b0;
      ready_q <= 1'b1;
    end else if (wr_en && !full_q) begin
      data_q  <= wr_data;
      full_q  <= 1'b1;
      ready_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] limit_m1,
  output logic             bit_end
);
  logic [CNT_W-1:0] cnt_q;

  assign bit_end = run && tick_en && (cnt_q == limit_m1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (run && tick_en) begin
      if (bit_end) cnt_q <= '0;
      else         cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              bit_end,
  output logic              busy_q,
  output logic              line_q
);
  localparam int FRAME_LEN = DATA_W + tx_pkg::FRAME_OVERHEAD;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic [DATA_W:0]  shreg_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      line_q  <= 1'b1;
      shreg_q <= '1;
      idx_q   <= '0;
    end else if (load) begin
      busy_q  <= 1'b1;
      line_q  <= 1'b0;
      shreg_q <= {1'b1, load_data};
      idx_q   <= '0;
    end else if (bit_end) begin
      if (idx_q == LAST_IDX) begin
        busy_q <= 1'b0;
        line_q <= 1'b1;
      end else begin
        line_q  <= shreg_q[0];
        shreg_q <= {1'b1, shreg_q[DATA_W:1]};
        idx_q   <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbl_serial_tx.sv
module dbl_serial_tx #(
  parameter int DATA_W  = 8,
  parameter int FACT_LO = 1,
  parameter int FACT_MD = 16,
  parameter int FACT_HI = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [1:0]        div_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_out,
  output logic              buf_ready,
  output logic              all_sent
);
  import tx_pkg::*;

  localparam int CNT_W = (FACT_HI > 1) ? $clog2(FACT_HI) : 1;
  localparam logic [CNT_W-1:0] LIM_LO = CNT_W'(FACT_LO - 1);
  localparam logic [CNT_W-1:0] LIM_MD = CNT_W'(FACT_MD - 1);
  localparam logic [CNT_W-1:0] LIM_HI = CNT_W'(FACT_HI - 1);

  logic [DATA_W-1:0] hold_q;
  logic              hold_full;
  logic              busy;
  logic              load;
  logic              bit_end;
  logic [CNT_W-1:0]  limit_m1;

  always_comb begin
    case (rate_sel_e'(div_sel))
      RATE_X1:  limit_m1 = LIM_LO;
      RATE_X16: limit_m1 = LIM_MD;
      default:  limit_m1 = LIM_HI;
    endcase
  end

  assign load     = hold_full && !busy;
  assign all_sent = buf_ready && !busy;

  tx_hold_buf #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (load),
    .data_q  (hold_q),
    .full_q  (hold_full),
    .ready_q (buf_ready)
  );

  tx_bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .restart  (load),
    .run      (busy),
    .tick_en  (tick_en),
    .limit_m1 (limit_m1),
    .bit_end  (bit_end)
  );

  tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_data (hold_q),
    .bit_end   (bit_end),
    .busy_q    (busy),
    .line_q    (tx_out)
  );
endmodule

// File: rtl/dbl_serial_tx_chk.sv
module dbl_serial_tx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              wr_en,
  input logic              buf_ready,
  input logic              all_sent,
  input logic              tx_out,
  input logic              load,
  input logic [DATA_W-1:0] hold_data
);
  logic rst_d;

  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d) begin
      assert_reset_idle_R1: assert (tx_out && buf_ready && all_sent)
        else $error("R1: outputs not idle after reset");
    end
  end

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
    all_sent |-> tx_out);

  assert_hold_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !buf_ready) |=> $stable(hold_data));

  assert_line_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !load) |=> $stable(tx_out));

  assert_empty_means_ready_R6: assert property (@(posedge clk) disable iff (rst)
    all_sent |-> buf_ready);

  assert_accept_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && buf_ready) |=> (!buf_ready && !all_sent));
endmodule

bind dbl_serial_tx dbl_serial_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_en   (tick_en),
  .wr_en     (wr_en),
  .buf_ready (buf_ready),
  .all_sent  (all_sent),
  .tx_out    (tx_out),
  .load      (load),
  .hold_data (hold_q)
);

// File: tb/dbl_serial_tx_tb.sv
module dbl_serial_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  // {div_sel[1:0], tick_gap[1:0], byte[7:0]}
  localparam logic [11:0] VECS [0:7] = '{
    {2'b00, 2'd1, 8'hA5},
    {2'b00, 2'd3, 8'h01},
    {2'b01, 2'd1, 8'h80},
    {2'b01, 2'd2, 8'h3C},
    {2'b10, 2'd1, 8'hFF},
    {2'b11, 2'd1, 8'h00},
    {2'b10, 2'd3, 8'h5A},
    {2'b00, 2'd2, 8'hC3}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic [1:0] div_sel = 2'b00;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tx_out, buf_ready, all_sent;

  int checks = 0;
  int errors = 0;
  int tick_gap = 1;
  int tick_ctr = 0;
  int cycles = 0;

  logic [7:0] expq [0:63];
  int wr_ptr = 0;
  int rd_ptr = 0;
  int frames = 0;

  bit   rx_on = 0;
  bit   rx_bad = 0;
  bit   rx_new = 0;
  bit   rx_post = 0;
  int   rx_bit = 0;
  int   rx_ticks = 0;
  logic [7:0] rx_byte = 8'h00;
  logic exp_lvl;

  dbl_serial_tx u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .div_sel(div_sel),
    .wr_en(wr_en), .wr_data(wr_data),
    .tx_out(tx_out), .buf_ready(buf_ready), .all_sent(all_sent)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int fact_of(input logic [1:0] s);
    case (s)
      2'b00:   return 1;
      2'b01:   return 16;
      default: return 64;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // tick generator, changed just after each rising edge
  always begin
    @(posedge clk);
    #1;
    if (tick_gap == 0) begin
      tick_en = 1'b0;
    end else begin
      tick_en = (tick_ctr == 0);
      tick_ctr = (tick_ctr + 1 >= tick_gap) ? 0 : tick_ctr + 1;
    end
  end

  // line receiver: checks frame shape, bit length in tick pulses, empty flag
  always @(negedge clk) begin
    cycles++;
    if (rst) begin
      rx_on = 0;
      rx_post = 0;
    end else begin
      if (rx_post) begin
        rx_post = 0;
        check(all_sent == (wr_ptr == rd_ptr), "R6 all_sent after stop", all_sent, wr_ptr == rd_ptr);
      end
      if (!rx_on && tx_out == 1'b0) begin
        rx_on = 1; rx_bit = 0; rx_ticks = 0; rx_bad = 0; rx_new = 1; rx_byte = 8'h00;
      end
      if (rx_on) begin
        if (rx_new && rx_bit >= 1 && rx_bit <= 8) rx_byte[rx_bit-1] = tx_out;
        rx_new = 0;
        if (rx_bit == 0)      exp_lvl = 1'b0;
        else if (rx_bit == 9) exp_lvl = 1'b1;
        else                  exp_lvl = rx_byte[rx_bit-1];
        if (tx_out !== exp_lvl) rx_bad = 1;
        if (all_sent !== 1'b0) rx_bad = 1;
        if (tick_en) begin
          rx_ticks++;
          if (rx_ticks == fact_of(div_sel)) begin
            rx_ticks = 0;
            rx_bit++;
            rx_new = 1;
            if (rx_bit == 10) begin
              rx_on = 0;
              frames++;
              if (wr_ptr == rd_ptr) begin
                check(1'b0, "R4 extra frame", rx_byte, 0);
              end else begin
                check(!rx_bad && rx_byte == expq[rd_ptr % 64],
                      "R2/R5/R6 frame shape and timing", {rx_bad, rx_byte}, expq[rd_ptr % 64]);
                rd_ptr++;
              end
              rx_post = 1;
            end
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic write_byte(input logic [7:0] b, output bit taken);
    @(negedge clk);
    taken = buf_ready;
    wr_en = 1'b1;
    wr_data = b;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    if (taken) begin
      expq[wr_ptr % 64] = b;
      wr_ptr++;
    end
  endtask

  task automatic wait_done();
    repeat (2) @(negedge clk);
    while (!all_sent) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  bit tk;
  int f0;
  int lows;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(tx_out === 1'b1, "R1 tx_out", tx_out, 1);
    check(buf_ready === 1'b1, "R1 buf_ready", buf_ready, 1);
    check(all_sent === 1'b1, "R1 all_sent", all_sent, 1);

    // table walk: R2 and R5 under every rate and tick spacing
    for (int i = 0; i < 8; i++) begin
      div_sel  = VECS[i][11:10];
      tick_gap = int'(VECS[i][9:8]);
      f0 = frames;
      write_byte(VECS[i][7:0], tk);
      check(tk, "R8 idle buffer accepts", tk, 1);
      wait_done();
      check(frames == f0 + 1, "R2 one frame per byte", frames - f0, 1);
    end

    // double buffering: R3, R8, R4, R6
    div_sel = 2'b01; tick_gap = 1;
    f0 = frames;
    write_byte(8'h96, tk);
    @(negedge clk);
    check(buf_ready === 1'b0, "R8 buffer full after write", buf_ready, 0);
    check(all_sent === 1'b0, "R6 all_sent low after write", all_sent, 0);
    @(negedge clk);
    check(buf_ready === 1'b1, "R3 buffer free after transfer", buf_ready, 1);
    check(tx_out === 1'b0, "R3 start bit after transfer", tx_out, 0);
    write_byte(8'h4B, tk);
    check(tk, "R3 second byte accepted while shifting", tk, 1);
    @(negedge clk);
    check(buf_ready === 1'b0, "R8 buffer full with frame running", buf_ready, 0);
    write_byte(8'hE7, tk);
    check(!tk, "R4 write refused while full", tk, 0);
    wait_done();
    check(frames == f0 + 2, "R4 ignored write sends nothing", frames - f0, 2);

    // tick held low: line frozen, R5
    div_sel = 2'b00; tick_gap = 0;
    write_byte(8'h11, tk);
    lows = 0;
    repeat (60) begin
      @(negedge clk);
      if (tx_out == 1'b0) lows++;
    end
    check(lows == 59, "R5 start bit held without ticks", lows, 59);
    tick_gap = 1;
    wait_done();

    // reset mid frame with a byte held: R7
    div_sel = 2'b01; tick_gap = 1;
    write_byte(8'h22, tk);
    repeat (3) @(negedge clk);
    write_byte(8'h33, tk);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    rd_ptr = wr_ptr;
    f0 = frames;
    @(negedge clk);
    check(tx_out === 1'b1, "R7 line idle after reset", tx_out, 1);
    check(buf_ready === 1'b1, "R7 buffer cleared", buf_ready, 1);
    check(all_sent === 1'b1, "R7 all_sent after reset", all_sent, 1);
    lows = 0;
    repeat (600) begin
      @(negedge clk);
      if (tx_out == 1'b0) lows++;
    end
    check(lows == 0 && frames == f0, "R7 dropped bytes not sent", lows, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule